// File: doc/BRIEF.md
# Multichannel Tone Command Decoder

This block takes a parallel tone command and files it into one of four channel slots whenever a write strobe arrives. A command has four fields: a channel select, an octave code, a semitone note code and a magnitude code. On each write, the note code is turned into an 8-bit half-period terminal count for a 120 kHz reference clock. That count is stored in the addressed slot along with the octave and magnitude codes.

Each slot drives its stored count, its octave code, its magnitude code and an active flag. These outputs feed the per-channel square-wave dividers and the level switches further down the chain. The strobe may be asynchronous to the clock. It is synchronised and edge-detected, so each assertion of the strobe loads exactly one command. The command fields must stay steady from the rise of the strobe until the load has taken place.

Top module: `tone_cmd_dec`

## Requirements
- R1: After reset, every slot holds count 0, octave code 00 and magnitude code 00, and every active flag is low.
- R2: The channel select picks the slot that is loaded: 00 selects slot 0 (count_o[7:0], oct_o[1:0], mag_o[1:0], active_o[0]), 01 slot 1, 10 slot 2 and 11 slot 3. A write changes no other slot.
- R3: Let edge E be the first rising clock edge that samples wr_i high. The load happens on the second rising edge after E, using the command inputs present at that load edge. Holding wr_i high does not cause a second load. A new load needs wr_i to be sampled low first.
- R4: The note code sets the stored count as round(60000 / f), where f is the note frequency in the octave from 523 to 988 Hz with A = 880 Hz. Note codes 0 through 11 map to B=61, A#=64, A=68, G#=72, G=77, F#=81, F=86, E=91, D#=96, D=102, C#=108 and C=115.
- R5: The magnitude code is stored as given. 00 means off, and 01, 10 and 11 mean small, normal and large. A slot's active flag is high exactly when its stored magnitude is not 00.
- R6: Octave codes 00 (above middle), 01 (middle) and 10 (below middle) are stored as given. They do not change the stored count.
- R7: A write with octave code 11 or note code 12 to 15 stores magnitude 00, count 0 and octave 00 in the addressed slot, and that slot's active flag goes low.
- R8: Changes on the command inputs have no effect on any slot unless a load is taking place.
- R9: A later write to a slot replaces all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, may be asynchronous |
| chan_sel_i | input | 2 | Slot to load |
| oct_i | input | 2 | Octave code |
| note_i | input | 4 | Semitone note code |
| mag_i | input | 2 | Magnitude code |
| count_o | output | 32 | Stored terminal counts, slot k at [8k+7:8k] |
| oct_o | output | 8 | Stored octave codes, slot k at [2k+1:2k] |
| mag_o | output | 8 | Stored magnitude codes, slot k at [2k+1:2k] |
| active_o | output | 4 | Per-slot active flags |

## Verification
The bench holds the strobe high for several cycles and changes the command fields after the load edge. A design that fires more than once per strobe, or that samples the command late, picks up the changed data. Every note code goes to every slot. A table error, or a select decode that writes the wrong slot or several slots, shows up as a mismatch in a slot that should not have moved. Invalid octave and note codes are mixed in with valid writes, so a design that only clears the magnitude, or that leaves a stale count or octave, is caught. Garbage on the inputs between strobes exposes any slot that loads outside a real write.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned CNT_W      = 8;
  localparam int unsigned NOTE_W     = 4;
  localparam int unsigned CODE_W     = 2;
  localparam int unsigned NOTE_COUNT = 12;

  typedef enum logic [CODE_W-1:0] {
    MAG_OFF   = 2'b00,
    MAG_SMALL = 2'b01,
    MAG_NORM  = 2'b10,
    MAG_LARGE = 2'b11
  } mag_e;

  typedef enum logic [CODE_W-1:0] {
    OCT_HIGH = 2'b00,
    OCT_MID  = 2'b01,
    OCT_LOW  = 2'b10,
    OCT_BAD  = 2'b11
  } oct_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    oct_e             oct;
    mag_e             mag;
  } slot_t;

  // half-period counts at 120 kHz, top octave, code 0 = B descending to 11 = C
  function automatic logic [CNT_W-1:0] note_count(input logic [NOTE_W-1:0] code);
    logic [CNT_W-1:0] c;
    case (code)
      4'd0:    c = 8'd61;
      4'd1:    c = 8'd64;
      4'd2:    c = 8'd68;
      4'd3:    c = 8'd72;
      4'd4:    c = 8'd77;
      4'd5:    c = 8'd81;
      4'd6:    c = 8'd86;
      4'd7:    c = 8'd91;
      4'd8:    c = 8'd96;
      4'd9:    c = 8'd102;
      4'd10:   c = 8'd108;
      4'd11:   c = 8'd115;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tone_wr_sync.sv
module tone_wr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic ld_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], wr_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ld_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tone_cmd_xlate.sv
module tone_cmd_xlate
  import tone_pkg::*;
(
  input  logic [NOTE_W-1:0] note_i,
  input  logic [CODE_W-1:0] oct_i,
  input  logic [CODE_W-1:0] mag_i,
  output slot_t             slot_o
);
  logic bad;

  always_comb begin
    bad = (oct_i == OCT_BAD) || (note_i >= NOTE_W'(NOTE_COUNT));
    if (bad) begin
      slot_o.count = '0;
      slot_o.oct   = OCT_HIGH;
      slot_o.mag   = MAG_OFF;
    end else begin
      slot_o.count = note_count(note_i);
      slot_o.oct   = oct_e'(oct_i);
      slot_o.mag   = mag_e'(mag_i);
    end
  end
endmodule

// File: rtl/tone_chan_slot.sv
module tone_chan_slot
  import tone_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  slot_t slot_i,
  output slot_t slot_o,
  output logic  active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o   <= '{count: '0, oct: OCT_HIGH, mag: MAG_OFF};
      active_o <= 1'b0;
    end else if (ld_i) begin
      slot_o   <= slot_i;
      active_o <= (slot_i.mag != MAG_OFF);
    end
  end
endmodule

// File: rtl/tone_cmd_dec.sv
module tone_cmd_dec
  import tone_pkg::*;
#(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(N_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [SEL_W-1:0]           chan_sel_i,
  input  logic [CODE_W-1:0]          oct_i,
  input  logic [NOTE_W-1:0]          note_i,
  input  logic [CODE_W-1:0]          mag_i,
  output logic [N_CH*CNT_W-1:0]      count_o,
  output logic [N_CH*CODE_W-1:0]     oct_o,
  output logic [N_CH*CODE_W-1:0]     mag_o,
  output logic [N_CH-1:0]            active_o
);
  logic  ld_pulse;
  slot_t cmd_slot;

  tone_wr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_i),
    .ld_o  (ld_pulse)
  );

  tone_cmd_xlate i_xlate (
    .note_i(note_i),
    .oct_i (oct_i),
    .mag_i (mag_i),
    .slot_o(cmd_slot)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    slot_t st;
    logic  ld_k;
    assign ld_k = ld_pulse && (chan_sel_i == SEL_W'(k));

    tone_chan_slot i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (ld_k),
      .slot_i  (cmd_slot),
      .slot_o  (st),
      .active_o(active_o[k])
    );

    assign count_o[k*CNT_W +: CNT_W]   = st.count;
    assign oct_o[k*CODE_W +: CODE_W]   = st.oct;
    assign mag_o[k*CODE_W +: CODE_W]   = st.mag;
  end
endmodule

// File: rtl/tone_cmd_dec_chk.sv
module tone_cmd_dec_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ld,
  input logic [SEL_W-1:0]      chan_sel_i,
  input logic [1:0]            oct_i,
  input logic [3:0]            note_i,
  input logic [N_CH*8-1:0]     count_o,
  input logic [N_CH*2-1:0]     oct_o,
  input logic [N_CH*2-1:0]     mag_o,
  input logic [N_CH-1:0]       active_o
);
  a_r3_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> !ld);

  for (genvar k = 0; k < N_CH; k++) begin : g_k
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ld && chan_sel_i == SEL_W'(k)) |=>
        ($stable(count_o[k*8 +: 8]) && $stable(oct_o[k*2 +: 2]) && $stable(mag_o[k*2 +: 2])));

    a_r5_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o[k] == (mag_o[k*2 +: 2] != 2'b00));

    a_r7_bad_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld && chan_sel_i == SEL_W'(k) && (oct_i == 2'b11 || note_i > 4'd11)) |=>
        (mag_o[k*2 +: 2] == 2'b00 && count_o[k*8 +: 8] == 8'd0 && !active_o[k]));

    a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o[k*8 +: 8] == 8'd0 || (count_o[k*8 +: 8] >= 8'd61 && count_o[k*8 +: 8] <= 8'd115));

    a_r6_oct_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oct_o[k*2 +: 2] != 2'b11);
  end
endmodule

bind tone_cmd_dec tone_cmd_dec_chk #(.N_CH(N_CH), .SEL_W(SEL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld        (ld_pulse),
  .chan_sel_i(chan_sel_i),
  .oct_i     (oct_i),
  .note_i    (note_i),
  .count_o   (count_o),
  .oct_o     (oct_o),
  .mag_o     (mag_o),
  .active_o  (active_o)
);

// File: tb/test_tone_cmd_dec.sv
module test_tone_cmd_dec;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int WDOG       = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr = 1'b0;
  logic [1:0]       sel = '0;
  logic [1:0]       oct = '0;
  logic [3:0]       note = '0;
  logic [1:0]       mag = '0;
  logic [NCH*8-1:0] count_o;
  logic [NCH*2-1:0] oct_o;
  logic [NCH*2-1:0] mag_o;
  logic [NCH-1:0]   active_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  int m_cnt[NCH];
  int m_oct[NCH];
  int m_mag[NCH];
  bit wr_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_cmd_dec i_tone_cmd_dec (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .chan_sel_i(sel), .oct_i(oct),
    .note_i(note), .mag_i(mag), .count_o(count_o), .oct_o(oct_o),
    .mag_o(mag_o), .active_o(active_o)
  );

  function automatic int exp_count(int code);
    real f;
    if (code > 11) return 0;
    f = 880.0 * (2.0 ** (real'((11 - code) - 9) / 12.0));
    return $rtoi(60000.0 / f + 0.5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: load on edge n when strobe sampled high at n-2 and low at n-3
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hist = {0, 0, 0, 0};
      for (int k = 0; k < NCH; k++) begin
        m_cnt[k] = 0; m_oct[k] = 0; m_mag[k] = 0;
      end
    end else begin
      wr_hist.push_front(wr);
      void'(wr_hist.pop_back());
      if (wr_hist[2] && !wr_hist[3]) begin
        if (oct == 2'b11 || note > 4'd11) begin
          m_cnt[sel] = 0; m_oct[sel] = 0; m_mag[sel] = 0;
        end else begin
          m_cnt[sel] = exp_count(int'(note));
          m_oct[sel] = int'(oct);
          m_mag[sel] = int'(mag);
        end
      end
    end
  end

  // per-clock comparison against the model (R2, R4, R5, R6, R7, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < NCH; k++) begin
        chk("R4", int'(count_o[k*8 +: 8]), m_cnt[k]);
        chk("R6", int'(oct_o[k*2 +: 2]), m_oct[k]);
        chk("R5", int'(mag_o[k*2 +: 2]), m_mag[k]);
        chk("R5", int'(active_o[k]), int'(m_mag[k] != 0));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WDOG);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic garble();
    oct = 2'($urandom); note = 4'($urandom); mag = 2'($urandom); sel = 2'($urandom);
  endtask

  // write: data held through the load edge, then garbled while strobe may still be high
  task automatic do_write(int ch, int o, int n, int m, int hold);
    @(negedge clk);
    sel = 2'(ch); oct = 2'(o); note = 4'(n); mag = 2'(m); wr = 1'b1;
    repeat (3) @(negedge clk);
    garble();
    if (hold > 3) repeat (hold - 3) @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int cnt_of(int k); return int'(count_o[k*8 +: 8]); endfunction
  function automatic int mag_of(int k); return int'(mag_o[k*2 +: 2]); endfunction
  function automatic int oct_of(int k); return int'(oct_o[k*2 +: 2]); endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < NCH; k++) begin
      chk("R1", cnt_of(k), 0);
      chk("R1", mag_of(k), 0);
      chk("R1", oct_of(k), 0);
      chk("R1", int'(active_o[k]), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: load timing, check before and at the load edge
    @(negedge clk);
    sel = 2'd1; oct = 2'd1; note = 4'd2; mag = 2'd2; wr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3", cnt_of(1), 0);
    @(negedge clk);
    chk("R3", cnt_of(1), 68);
    garble();
    repeat (5) @(negedge clk);
    chk("R3", cnt_of(1), 68);
    wr = 1'b0;
    repeat (4) @(negedge clk);

    // R2 + R4: every note into every slot
    for (int n = 0; n < 12; n++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        do_write(ch, (n + ch) % 3, (n + ch) % 12, 1 + (n % 3), 1 + (ch % 2) * 5);
        chk("R2", cnt_of(ch), exp_count((n + ch) % 12));
        chk("R4", cnt_of(ch), exp_count((n + ch) % 12));
      end
    end
    do_write(0, 1, 2, 1, 4);
    chk("R4", cnt_of(0), 68);
    do_write(0, 0, 11, 3, 4);
    chk("R4", cnt_of(0), 115);
    do_write(0, 2, 0, 2, 4);
    chk("R4", cnt_of(0), 61);
    chk("R6", oct_of(0), 2);

    // R5: off code clears active flag
    do_write(2, 1, 5, 0, 4);
    chk("R5", int'(active_o[2]), 0);
    do_write(2, 1, 5, 3, 4);
    chk("R5", int'(active_o[2]), 1);
    chk("R5", mag_of(2), 3);

    // R7: invalid octave and invalid note
    do_write(3, 3, 4, 2, 4);
    chk("R7", mag_of(3), 0);
    chk("R7", cnt_of(3), 0);
    chk("R7", int'(active_o[3]), 0);
    do_write(3, 0, 7, 2, 4);
    do_write(3, 1, 13, 1, 4);
    chk("R7", cnt_of(3), 0);
    chk("R7", oct_of(3), 0);

    // R9: overwrite replaces all fields
    do_write(1, 2, 9, 1, 1);
    do_write(1, 0, 6, 3, 1);
    chk("R9", cnt_of(1), 86);
    chk("R9", oct_of(1), 0);
    chk("R9", mag_of(1), 3);

    // R8: input noise without a strobe
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      garble();
    end
    chk("R8", cnt_of(1), 86);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule